// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, every clock cycle, which hardware thread may send an instruction into a pipeline that several threads share. Its output is a valid flag and a thread number. The thread number travels with the instruction, so that later stages read and write the state that belongs to that thread. The decision depends on the current cycle's per-thread ready flags and on a policy input, and there is no register between them and the output. The block offers three policies:

- **Fixed interleave.** Slots rotate strictly among the threads.
- **Slot table.** Software loads the table, and the block walks it one entry per cycle.
- **Hardware choice.** The block picks among the ready threads and favours the one with the fewest instructions in flight.

The selector counts in-flight instructions for each thread itself. A thread's count goes up when the block issues for that thread, and goes down on that thread's retire pulse. When hardware choice finds several threads tied on the lowest count, a rotating pointer breaks the tie. Software writes slot-table entries at any time, but a write only takes effect when the table pointer next wraps, so the table never changes part-way through a pass.

Top module: `thread_select`

## Requirements
- R1: After reset:
  - the fixed-slot owner is thread 0;
  - the table pointer is at entry 0;
  - every table entry k, live and pending, holds thread k mod N;
  - every in-flight count is 0;
  - the rotating pointer is at thread 0.
- R2: Policy 2'b00 (fixed interleave):
  - the output thread is the slot owner, which steps to owner+1 mod N every cycle whether or not an instruction issues;
  - valid equals the owner's ready flag.
- R3: In fixed interleave, a slot whose owner is not ready yields valid low, and no other thread gets that slot.
- R4: In fixed interleave, two issues for the same thread are never closer than N cycles. With all threads ready they are exactly N cycles apart, so with 4 threads in a 5-stage pipeline, a thread's next fetch never overtakes the writeback of its previous instruction.
- R5: Policy 2'b01 (slot table):
  - each cycle, the output thread is the live entry at the table pointer, and valid is that thread's ready flag;
  - the pointer advances by one every cycle of this policy and wraps from entry SLOT_DEPTH-1 to entry 0.
- R6: A table write (entry address and 2-bit thread value) goes into a pending copy. The whole pending copy, including a write made in that same cycle, becomes live on the clock edge where the pointer wraps from the last entry to entry 0. Until that edge the output follows the old live contents.
- R7: Policy 2'b10 (hardware choice):
  - valid is high exactly when at least one ready flag is set;
  - the chosen thread is ready and has the lowest in-flight count among the ready threads.
- R8: In hardware choice, a tie on the lowest count goes to the first tied thread at or after the rotating pointer, in cyclic order. After each issue in this policy the pointer moves to the winner+1 mod N.
- R9: In hardware choice with no thread ready, valid is low and the rotating pointer keeps its value.
- R10: In-flight counts, which can be observed through the selection in hardware choice:
  - an issue for a thread adds one to its count, and that thread's retire pulse subtracts one;
  - when both happen in the same cycle the count is unchanged;
  - a retire at count 0 is ignored, and an issue at the maximum count (2^CNT_W-1) leaves the count at the maximum.
- R11: Policy 2'b11 behaves like 2'b10. The fixed-slot owner moves only while fixed interleave is selected, the table pointer only while the slot table is selected, and the rotating pointer only while hardware choice is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | 00 fixed interleave, 01 slot table, 10/11 hardware choice |
| ready_i | input | N_THREADS | Per-thread ready flags |
| retire_i | input | N_THREADS | Per-thread retire pulses |
| tbl_we_i | input | 1 | Slot-table write enable |
| tbl_addr_i | input | SLOT_W | Slot-table entry address |
| tbl_data_i | input | TID_W | Thread number to store |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | TID_W | Thread number that goes with the issue |

## Verification
Most internal errors show up at the ports within the same cycle or the next one:

- **Fixed-slot owner.** A wrong owner shows on issue_tid_o at once, because the thread number is driven from it every fixed-interleave cycle.
- **Table pointer.** A pointer that skips or stalls shows in the next cycle of the slot table.
- **Table commit.** A pending copy that becomes live at the wrong edge stays hidden until the walk reaches an entry that was rewritten, which can be up to SLOT_DEPTH cycles later.

In-flight counts that drift are the slowest to appear. A wrong count changes nothing until, in hardware choice, two ready threads are compared whose true counts are close, so the bench keeps counts small and fills, drains and saturates them on purpose.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    POL_FIXED  = 2'b00,
    POL_TABLE  = 2'b01,
    POL_HW     = 2'b10,
    POL_HW_ALT = 2'b11
  } policy_e;

  function automatic logic is_hw(input policy_e p);
    return (p == POL_HW) || (p == POL_HW_ALT);
  endfunction
endpackage

// File: rtl/ts_inflight_cnt.sv
module ts_inflight_cnt #(
  parameter int N_THREADS = 4,
  parameter int CNT_W     = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_THREADS-1:0]                inc_i,
  input  logic [N_THREADS-1:0]                dec_i,
  output logic [N_THREADS-1:0][CNT_W-1:0]     cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [N_THREADS-1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
    logic dec_ok;
    assign dec_ok = dec_i[g] && (cnt_q[g] != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (inc_i[g] && !dec_ok) begin
        if (cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + 1'b1;
      end else if (dec_ok && !inc_i[g]) begin
        cnt_q[g] <= cnt_q[g] - 1'b1;
      end
    end

    // R10
    cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[g] == CNT_MAX && inc_i[g] && !dec_i[g]) |=> (cnt_q[g] == CNT_MAX));
    // R10
    cnt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[g] == '0 && dec_i[g] && !inc_i[g]) |=> (cnt_q[g] == '0));
    // R10
    cnt_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[g] != '0 && dec_i[g] && inc_i[g]) |=> $stable(cnt_q[g]));
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ts_slot_table.sv
module ts_slot_table #(
  parameter int N_THREADS  = 4,
  parameter int SLOT_DEPTH = 8,
  parameter int TID_W      = 2,
  parameter int SLOT_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  logic [TID_W-1:0]  wdata_i,
  output logic [TID_W-1:0]  slot_tid_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOT_DEPTH - 1);

  logic [SLOT_DEPTH-1:0][TID_W-1:0] live_q, pend_q, pend_d;
  logic [SLOT_W-1:0]                ptr_q;
  logic                             wrap;

  assign wrap = adv_i && (ptr_q == LAST);

  always_comb begin
    pend_d = pend_q;
    if (we_i) pend_d[waddr_i] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int k = 0; k < SLOT_DEPTH; k++) begin
        live_q[k] <= TID_W'(k % N_THREADS);
        pend_q[k] <= TID_W'(k % N_THREADS);
      end
    end else begin
      pend_q <= pend_d;
      if (wrap) live_q <= pend_d;
      if (adv_i) ptr_q <= wrap ? '0 : ptr_q + 1'b1;
    end
  end

  assign slot_tid_o = live_q[ptr_q];

  // R6
  tbl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(live_q));
  // R5
  tbl_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (($past(ptr_q) == LAST) ? (ptr_q == '0) : (ptr_q == $past(ptr_q) + 1'b1)));
  // R11
  tbl_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/ts_fewest_pick.sv
module ts_fewest_pick #(
  parameter int N_THREADS = 4,
  parameter int CNT_W     = 4,
  parameter int TID_W     = 2
) (
  input  logic [N_THREADS-1:0]            ready_i,
  input  logic [N_THREADS-1:0][CNT_W-1:0] cnt_i,
  input  logic [TID_W-1:0]                start_i,
  output logic                            found_o,
  output logic [TID_W-1:0]                win_o
);
  // Scan from start_i cyclically; strict less-than keeps the earliest tie.
  always_comb begin
    logic [CNT_W-1:0] best;
    int               idx;
    found_o = 1'b0;
    win_o   = start_i;
    best    = '0;
    for (int k = 0; k < N_THREADS; k++) begin
      idx = (int'(start_i) + k) % N_THREADS;
      if (ready_i[idx] && (!found_o || cnt_i[idx] < best)) begin
        found_o = 1'b1;
        best    = cnt_i[idx];
        win_o   = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/thread_select.sv
module thread_select
  import ts_pkg::*;
#(
  parameter int N_THREADS  = 4,
  parameter int SLOT_DEPTH = 8,
  parameter int CNT_W      = 4,
  localparam int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int SLOT_W    = (SLOT_DEPTH > 1) ? $clog2(SLOT_DEPTH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           policy_i,
  input  logic [N_THREADS-1:0] ready_i,
  input  logic [N_THREADS-1:0] retire_i,
  input  logic                 tbl_we_i,
  input  logic [SLOT_W-1:0]    tbl_addr_i,
  input  logic [TID_W-1:0]     tbl_data_i,
  output logic                 issue_valid_o,
  output logic [TID_W-1:0]     issue_tid_o
);
  localparam logic [TID_W-1:0] TID_LAST = TID_W'(N_THREADS - 1);

  function automatic logic [TID_W-1:0] tid_next(input logic [TID_W-1:0] t);
    return (t == TID_LAST) ? '0 : t + 1'b1;
  endfunction

  policy_e                         pol;
  logic                            pol_hw;
  logic [TID_W-1:0]                fix_q, rr_q, slot_tid, win_tid;
  logic                            hw_found;
  logic [N_THREADS-1:0]            issue_vec;
  logic [N_THREADS-1:0][CNT_W-1:0] cnt;

  assign pol    = policy_e'(policy_i);
  assign pol_hw = is_hw(pol);

  ts_inflight_cnt #(.N_THREADS(N_THREADS), .CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (issue_vec),
    .dec_i  (retire_i),
    .cnt_o  (cnt)
  );

  ts_slot_table #(
    .N_THREADS(N_THREADS), .SLOT_DEPTH(SLOT_DEPTH), .TID_W(TID_W), .SLOT_W(SLOT_W)
  ) i_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (pol == POL_TABLE),
    .we_i       (tbl_we_i),
    .waddr_i    (tbl_addr_i),
    .wdata_i    (tbl_data_i),
    .slot_tid_o (slot_tid)
  );

  ts_fewest_pick #(.N_THREADS(N_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) i_pick (
    .ready_i (ready_i),
    .cnt_i   (cnt),
    .start_i (rr_q),
    .found_o (hw_found),
    .win_o   (win_tid)
  );

  always_comb begin
    unique case (pol)
      POL_FIXED: begin
        issue_tid_o   = fix_q;
        issue_valid_o = ready_i[fix_q];
      end
      POL_TABLE: begin
        issue_tid_o   = slot_tid;
        issue_valid_o = ready_i[slot_tid];
      end
      default: begin
        issue_tid_o   = win_tid;
        issue_valid_o = hw_found;
      end
    endcase
  end

  for (genvar g = 0; g < N_THREADS; g++) begin : g_iss
    assign issue_vec[g] = issue_valid_o && (issue_tid_o == TID_W'(g));

    // R7
    min_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pol_hw && issue_valid_o && ready_i[g]) |-> (cnt[g] >= cnt[issue_tid_o]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fix_q <= '0;
      rr_q  <= '0;
    end else begin
      if (pol == POL_FIXED) fix_q <= tid_next(fix_q);
      if (pol_hw && hw_found) rr_q <= tid_next(win_tid);
    end
  end

  // R3 R5 R7
  issue_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ready_i[issue_tid_o]);
  // R2
  fix_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol == POL_FIXED) ##1 (pol == POL_FIXED) |-> (issue_tid_o == tid_next($past(issue_tid_o))));
  // R9
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_hw && ready_i == '0) |=> $stable(rr_q));
  // R11
  fix_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol != POL_FIXED) |=> $stable(fix_q));
endmodule

// File: tb/test_thread_select.sv
`timescale 1ns/1ps
module test_thread_select;
  localparam int N = 4;
  localparam int D = 8;
  localparam int CMAX = 15;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] policy_i = 2'b00;
  logic [3:0] ready_i = '0;
  logic [3:0] retire_i = '0;
  logic       tbl_we_i = 1'b0;
  logic [2:0] tbl_addr_i = '0;
  logic [1:0] tbl_data_i = '0;
  logic       issue_valid_o;
  logic [1:0] issue_tid_o;

  always #2 clk_i = ~clk_i;

  thread_select i_thread_select (
    .clk_i, .rst_ni, .policy_i, .ready_i, .retire_i,
    .tbl_we_i, .tbl_addr_i, .tbl_data_i, .issue_valid_o, .issue_tid_o
  );

  int vectors = 0;
  int fails = 0;
  int m_fix, m_tptr, m_rr;
  int m_cnt[N];
  int m_live[D];
  int m_pend[D];
  int cyc = 0;
  bit track_r4 = 0;
  int last_iss[N];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic model_expect(input logic [1:0] pol, input logic [3:0] rdy,
                              output logic v, output int t, output bit tie);
    bit found = 0;
    int best = 0;
    int nmin = 0;
    tie = 0;
    if (pol == 2'b00) begin
      t = m_fix; v = rdy[m_fix];
    end else if (pol == 2'b01) begin
      t = m_live[m_tptr]; v = rdy[t];
    end else begin
      t = m_rr;
      for (int k = 0; k < N; k++) begin
        int idx = (m_rr + k) % N;
        if (rdy[idx] && (!found || m_cnt[idx] < best)) begin
          found = 1; best = m_cnt[idx]; t = idx;
        end
      end
      for (int k = 0; k < N; k++) if (rdy[k] && m_cnt[k] == best) nmin++;
      tie = (nmin > 1);
      v = found;
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [1:0] pol, input logic [3:0] rdy, input logic [3:0] ret,
                      input logic we, input int addr, input int data, input string tag);
    logic ev;
    int et;
    bit tie;
    string t;
    @(negedge clk_i);
    policy_i = pol; ready_i = rdy; retire_i = ret;
    tbl_we_i = we; tbl_addr_i = 3'(addr); tbl_data_i = 2'(data);
    #1;
    model_expect(pol, rdy, ev, et, tie);
    if (tag != "") t = tag;
    else if (pol == 2'b00) t = ev ? "R2" : "R3";
    else if (pol == 2'b01) t = (m_live[m_tptr] != m_pend[m_tptr]) ? "R6" : "R5";
    else if (pol == 2'b11) t = "R11";
    else if (!ev) t = "R9";
    else t = tie ? "R8" : "R7";
    check(t, "valid", int'(issue_valid_o), int'(ev));
    if (ev || pol != 2'b01) check(t, "tid", int'(issue_tid_o), et);
    if (track_r4 && issue_valid_o) begin
      int tt = int'(issue_tid_o);
      if (last_iss[tt] >= 0)
        check("R4", "issue spacing ok", int'((cyc - last_iss[tt]) >= N), 1);
      last_iss[tt] = cyc;
    end
    @(posedge clk_i);
    cyc++;
    for (int i = 0; i < N; i++) begin
      bit inc = ev && (et == i);
      bit dec = ret[i] && (m_cnt[i] > 0);
      if (inc && !dec && m_cnt[i] < CMAX) m_cnt[i]++;
      else if (dec && !inc) m_cnt[i]--;
    end
    if (we) m_pend[addr] = data;
    if (pol == 2'b01) begin
      if (m_tptr == D - 1) for (int k = 0; k < D; k++) m_live[k] = m_pend[k];
      m_tptr = (m_tptr + 1) % D;
    end
    if (pol == 2'b00) m_fix = (m_fix + 1) % N;
    if (pol[1] && ev) m_rr = (et + 1) % N;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_fix = 0; m_tptr = 0; m_rr = 0;
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; last_iss[i] = -1; end
    for (int k = 0; k < D; k++) begin m_live[k] = k % N; m_pend[k] = k % N; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state seen through each policy
    step(2'b00, 4'hF, 4'h0, 0, 0, 0, "R1");
    step(2'b01, 4'hF, 4'h0, 0, 0, 0, "R1");
    step(2'b10, 4'hE, 4'h0, 0, 0, 0, "R1");

    // R2 R3 R4 fixed interleave sweep: every ready pattern against every owner
    track_r4 = 1;
    for (int c = 0; c < 16; c++) step(2'b00, 4'hF, 4'hF, 0, 0, 0, "");
    for (int c = 0; c < 64; c++) begin
      lfsr = lfsr_next(lfsr);
      step(2'b00, 4'(c >> 2), lfsr[3:0], 0, 0, 0, "");
    end
    track_r4 = 0;

    // R5 R6 slot table: default walk, then rewrite mid-pass
    for (int c = 0; c < 8; c++) step(2'b01, 4'hF, 4'hF, 0, 0, 0, "");
    for (int c = 0; c < 3; c++) step(2'b01, 4'hF, 4'hF, 0, 0, 0, "");
    for (int a = 0; a < D; a++) step(2'b01, 4'hF, 4'hF, 1, a, (a < 4) ? 2 : 3 - (a & 1), "R6");
    for (int c = 0; c < 40; c++) begin
      lfsr = lfsr_next(lfsr);
      step(2'b01, lfsr[7:4] | ((c < 16) ? 4'hF : 4'h0), 4'hF, 0, 0, 0, "");
    end
    // write on the wrap cycle itself
    while (m_tptr != D - 1) step(2'b01, 4'hF, 4'hF, 0, 0, 0, "");
    step(2'b01, 4'hF, 4'hF, 1, 0, 1, "R6");
    for (int c = 0; c < 8; c++) step(2'b01, 4'hF, 4'hF, 0, 0, 0, "");

    // R7 R8 R9 hardware choice with mixed readiness and retires
    for (int c = 0; c < 300; c++) begin
      lfsr = lfsr_next(lfsr);
      step(2'b10, (c % 5 == 4) ? 4'h0 : lfsr[3:0], lfsr[7:4] & lfsr[11:8], 0, 0, 0, "");
    end

    // R10 fill to saturation, then drain past zero
    for (int c = 0; c < 80; c++) step(2'b10, 4'hF, 4'h0, 0, 0, 0, "R10");
    for (int c = 0; c < 20; c++) step(2'b10, 4'h0, 4'hF, 0, 0, 0, "R10");
    for (int c = 0; c < 8; c++) step(2'b10, 4'hF, 4'h0, 0, 0, 0, "R10");
    for (int c = 0; c < 12; c++) step(2'b10, 4'hF, 4'hF, 0, 0, 0, "R10");
    for (int c = 0; c < 12; c++) step(2'b10, 4'h5, 4'h0, 0, 0, 0, "R10");

    // R11 alternate hardware code, then policy mixing with table writes
    for (int c = 0; c < 40; c++) begin
      lfsr = lfsr_next(lfsr);
      step(2'b11, lfsr[3:0], lfsr[7:4], 0, 0, 0, "");
    end
    for (int c = 0; c < 240; c++) begin
      lfsr = lfsr_next(lfsr);
      step(lfsr[9:8], lfsr[3:0] | 4'(lfsr[12]), lfsr[7:4] & 4'(lfsr[13:10]),
           lfsr[14], int'(lfsr[2:0]), int'(lfsr[6:5]), "");
    end

    finish_run();
  end
endmodule